// File: doc/BRIEF.md
# Ethernet Manchester Transmit Encoder

This block sits between a LAN controller's serial transmit interface and the line side of a 10 Mb/s Ethernet port. It runs from a master clock that is nominally 20 MHz. It divides that clock by two to give the controller its 10 MHz transmit clock. While the controller holds the enable high, the block samples one data bit on each rising edge of that transmit clock. It emits each bit as one Manchester cell. The cell has two halves, and each half lasts one master clock period.

The encoded level and a line-active flag go to one of two line-side ports, twisted pair or AUI. The port is picked by a select input that is captured when a frame starts. The end of a frame depends on its final bit. After a final one, the line goes back to idle at the middle of the cell. After a final zero, it goes back to idle at the cell boundary. A frame only one bit long always sends its whole cell.

Top module: `mtx_encoder`

## Requirements
- R1: `txc_o` is the master clock divided by two. It is low in the first cycle after reset and toggles on every master clock edge after that.
- R2: Each bit taken in becomes one cell of two master clock periods. The first half carries the inverted bit and the second half carries the bit itself, so the level always changes at the middle of the cell.
- R3: `txd_i` is sampled at the master edge that makes `txc_o` rise, but only if `txen_i` is high at that edge. The first half of that bit's cell appears on the line at the next master edge.
- R4: When no cell is being sent, both active flags are low and both data outputs sit at the idle level 1. `txd_i` has no effect while `txen_i` is low.
- R5: In a frame of two or more bits whose last bit is 1, the active flag falls at the middle of the last cell, and the data output goes to 1 at that same point.
- R6: In a frame whose last bit is 0, the whole last cell is sent, and the active flag falls at the cell boundary.
- R7: A frame of exactly one bit sends its complete cell, whatever the bit value, and then ends at the cell boundary.
- R8: `port_sel_i` = 0 sends the cells to the twisted-pair outputs, and 1 sends them to the AUI outputs. The port that is not selected stays idle.
- R9: `port_sel_i` is captured at the sample edge that starts a frame. Changing it later in the frame does not move the cells to the other port.
- R10: A synchronous reset ends any frame in progress. After the reset edge both ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, nominally 20 MHz |
| rst | input | 1 | Synchronous reset, active high |
| txen_i | input | 1 | Transmit enable from the controller |
| txd_i | input | 1 | Serial transmit data from the controller |
| port_sel_i | input | 1 | Port select: 0 twisted pair, 1 AUI |
| txc_o | output | 1 | 10 MHz transmit clock to the controller |
| tp_data_o | output | 1 | Encoded level toward the twisted-pair path |
| tp_active_o | output | 1 | Frame activity toward the twisted-pair path |
| aui_data_o | output | 1 | Encoded level toward the AUI path |
| aui_active_o | output | 1 | Frame activity toward the AUI path |

## Verification
Four properties are checked on every cycle. The transmit clock toggles on every edge. Wherever a first half is followed by a second half, the level changes at mid-cell. Activity only ever starts at a cell's first half. At most one port is active at a time, and the captured port choice does not change while a port is active. Other behaviour can only be shown by the bench's scenarios. That covers the exact delay from a sampled bit to its cell, the cut-short final cell after a trailing one and the full cell after a trailing zero, and the one-bit frame exception. It also covers that a select change in mid-frame is ignored, and that a reset aborts a frame.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic {
        PORT_TP  = 1'b0,
        PORT_AUI = 1'b1
    } port_e;

    localparam int NPORT = 2;

    // one bit captured from the controller
    typedef struct packed {
        logic vld;    // bit belongs to a frame
        logic dbit;   // sampled data value
        logic first;  // first bit of its frame
    } cap_t;

    // state of the line toward one port
    typedef struct packed {
        logic active;
        logic level;
    } line_t;

    function automatic line_t idle_line(input logic idle_lvl);
        line_t l;
        l.active = 1'b0;
        l.level  = idle_lvl;
        return l;
    endfunction

endpackage

// File: rtl/mtx_phase.sv
module mtx_phase (
    input  logic clk,
    input  logic rst,
    output logic ph_o
);
    // ph_o low: the coming edge is a sample edge (TXC rises)
    always_ff @(posedge clk) begin
        if (rst) ph_o <= 1'b0;
        else     ph_o <= ~ph_o;
    end

    assert_txc_toggle_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ph_o != $past(ph_o));
endmodule

// File: rtl/mtx_sampler.sv
module mtx_sampler
    import mtx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ph_i,
    input  logic  txen_i,
    input  logic  txd_i,
    input  logic  port_sel_i,
    output cap_t  cap_o,
    output port_e sel_o
);
    logic frame_start;
    assign frame_start = txen_i && !cap_o.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_o <= '0;
            sel_o <= PORT_TP;
        end else if (!ph_i) begin
            cap_o.vld   <= txen_i;
            cap_o.dbit  <= txd_i;
            cap_o.first <= frame_start;
            if (frame_start) sel_o <= port_e'(port_sel_i);
        end
    end
endmodule

// File: rtl/mtx_cellgen.sv
module mtx_cellgen
    import mtx_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ph_i,
    input  cap_t  cap_i,
    input  logic  txen_i,
    output line_t line_o
);
    line_t nxt;
    logic  cut_short;

    // final bit is a one in a frame longer than one bit
    assign cut_short = !txen_i && cap_i.dbit && !cap_i.first;

    always_comb begin
        nxt = idle_line(IDLE_LVL);
        if (cap_i.vld) begin
            if (ph_i) begin
                nxt.active = 1'b1;
                nxt.level  = ~cap_i.dbit;
            end else if (!cut_short) begin
                nxt.active = 1'b1;
                nxt.level  = cap_i.dbit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_o <= idle_line(IDLE_LVL);
        else     line_o <= nxt;
    end

    // a first half followed by a driven second half changes level
    assert_mid_transition_R2: assert property (@(posedge clk) disable iff (rst)
        (line_o.active && !ph_i) |=> (!line_o.active || line_o.level != $past(line_o.level)));

    // activity only ever begins with a first half
    assert_start_first_half_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(line_o.active) |-> !ph_i);
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
    import mtx_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic txen_i,
    input  logic txd_i,
    input  logic port_sel_i,
    output logic txc_o,
    output logic tp_data_o,
    output logic tp_active_o,
    output logic aui_data_o,
    output logic aui_active_o
);
    logic  ph;
    cap_t  cap;
    port_e sel;
    line_t line;
    line_t port_line [NPORT];

    mtx_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .ph_o (ph)
    );

    mtx_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .ph_i       (ph),
        .txen_i     (txen_i),
        .txd_i      (txd_i),
        .port_sel_i (port_sel_i),
        .cap_o      (cap),
        .sel_o      (sel)
    );

    mtx_cellgen #(.IDLE_LVL(IDLE_LVL)) u_cellgen (
        .clk    (clk),
        .rst    (rst),
        .ph_i   (ph),
        .cap_i  (cap),
        .txen_i (txen_i),
        .line_o (line)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_route
        assign port_line[p] = (int'(sel) == p) ? line : idle_line(IDLE_LVL);
    end

    assign txc_o        = ph;
    assign tp_data_o    = port_line[PORT_TP].level;
    assign tp_active_o  = port_line[PORT_TP].active;
    assign aui_data_o   = port_line[PORT_AUI].level;
    assign aui_active_o = port_line[PORT_AUI].active;

    assert_single_port_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tp_active_o, aui_active_o}));

    assert_sel_held_R9: assert property (@(posedge clk) disable iff (rst)
        (tp_active_o || aui_active_o) |-> $stable(sel));
endmodule

// File: tb/mtx_encoder_bench.sv
module mtx_encoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txen = 1'b0;
    logic txd = 1'b0;
    logic psel = 1'b0;
    logic txc, tp_d, tp_a, aui_d, aui_a;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mtx_encoder u_mtx_encoder (
        .clk (clk), .rst (rst), .txen_i (txen), .txd_i (txd),
        .port_sel_i (psel), .txc_o (txc),
        .tp_data_o (tp_d), .tp_active_o (tp_a),
        .aui_data_o (aui_d), .aui_active_o (aui_a)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compares {tp_a,tp_d,aui_a,aui_d} with the expected line state
    task automatic expect_line(input string req, input bit act, input bit lvl, input bit sel);
        logic [3:0] e;
        logic [3:0] a;
        e = 4'b0101;
        if (act) begin
            if (sel) e[1:0] = {1'b1, lvl};
            else     e[3:2] = {1'b1, lvl};
        end
        a = {tp_a, tp_d, aui_a, aui_d};
        chk(a === e, req, "line{tp_a,tp_d,aui_a,aui_d}", int'(a), int'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; txen = 1'b0; txd = 1'b0;
        repeat (3) @(negedge clk);
        chk(txc === 1'b0, "R1", "txc in reset", int'(txc), 0);
        expect_line("R10", 1'b0, 1'b1, 1'b0);
        rst = 1'b0;
    endtask

    // sends n bits (bit 0 first); optionally flips port_sel mid-frame
    task automatic run_frame(input logic [63:0] bits, input int n,
                             input bit sel, input bit flip, input string tag);
        bit last;
        last = bits[n-1];
        @(negedge clk);
        while (txc !== 1'b0) @(negedge clk);
        for (int k = 0; k <= 2*n + 5; k++) begin
            if (k >= 1) begin
                string req;
                bit ea;
                bit el;
                chk(txc === k[0], "R1", {tag, " txc phase"}, int'(txc), int'(k[0]));
                ea = 1'b0; el = 1'b1;
                req = flip ? "R9" : (sel ? "R8" : "R2");
                if (k >= 2 && k < 2*n + 2) begin
                    int i;
                    bit h;
                    i = (k - 2) / 2;
                    h = k[0];
                    if (k == 2) req = "R3";
                    if (n == 1) req = "R7";
                    if (i == n - 1 && h) begin
                        if (n == 1)     req = "R7";
                        else if (last)  req = "R5";
                        else            req = "R6";
                    end
                    if (!(i == n - 1 && h && n > 1 && last)) begin
                        ea = 1'b1;
                        el = h ? bits[i] : ~bits[i];
                    end
                end else if (k >= 2*n + 2) begin
                    req = "R4";
                end
                expect_line(req, ea, el, sel);
            end
            if (k == 0) psel = sel;
            if (k == 3 && flip) psel = ~sel;
            if (!k[0]) begin
                if (k / 2 < n) begin
                    txen = 1'b1; txd = bits[k/2];
                end else begin
                    txen = 1'b0; txd = ~txd;
                end
            end
            @(negedge clk);
        end
        txen = 1'b0;
    endtask

    task automatic idle_noise();
        for (int k = 0; k < 30; k++) begin
            txen = 1'b0; txd = k[0]; psel = k[1];
            @(negedge clk);
            expect_line("R4", 1'b0, 1'b1, 1'b0);
        end
        psel = 1'b0;
    endtask

    task automatic reset_abort();
        @(negedge clk);
        while (txc !== 1'b0) @(negedge clk);
        txen = 1'b1; txd = 1'b0;
        repeat (5) @(negedge clk);
        chk(tp_a === 1'b1, "R10", "frame running before reset", int'(tp_a), 1);
        rst = 1'b1;
        @(negedge clk);
        expect_line("R10", 1'b0, 1'b1, 1'b0);
        chk(txc === 1'b0, "R10", "txc after reset edge", int'(txc), 0);
        txen = 1'b0;
        rst = 1'b0;
        repeat (4) @(negedge clk);
        expect_line("R10", 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        do_reset();
        idle_noise();
        run_frame(64'h0000_0000_0000_00D5, 8, 1'b0, 1'b0, "tail one");
        run_frame(64'h0000_0000_0000_0055, 8, 1'b0, 1'b0, "tail zero");
        run_frame(64'h0000_0000_0000_0001, 1, 1'b0, 1'b0, "single one");
        run_frame(64'h0000_0000_0000_0000, 1, 1'b0, 1'b0, "single zero");
        run_frame(64'h0000_0000_0000_0003, 2, 1'b0, 1'b0, "two ones");
        run_frame(64'h0000_0000_0000_3A6C, 16, 1'b1, 1'b0, "aui port");
        run_frame(64'h0000_0000_0000_00A7, 8, 1'b0, 1'b1, "sel flip tp");
        run_frame(64'h0000_0000_0000_00B2, 8, 1'b1, 1'b1, "sel flip aui");
        reset_abort();
        idle_noise();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule